// File: doc/BRIEF.md
# Chunked Register-Window Data FIFOs

This block buffers the data phase of software-issued flash commands. It holds a transmit FIFO and a receive FIFO, each 64 bits wide, between a 32-bit register bus and a flash sequencer. Software does not push or pop single words. It builds or reads one 8-byte chunk through a fixed two-word register window. It then commits the chunk to transmit, or releases it from receive, by writing 1 to a flag in a write-one-to-clear flag register.

On the sequencer side, each FIFO is a byte stream with a valid/ready handshake. Transmit bytes leave in order, least significant byte first. Receive bytes are packed eight at a time into an entry. Each FIFO has a clear control and a status word. The status word gives the fill level and a running count of chunks moved. Pushing into a full transmit FIFO, or releasing from an empty receive FIFO, is refused and latched as a sticky error flag.

Top module: `ipfifo_window`

## Requirements
- R1: After reset both FIFOs are empty. The flag register (0x14) reads 0x00000040, both status words read 0, `tx_out_valid` is 0 and `rx_in_ready` is 1.
- R2: Writing 0x180 sets bits 31:0 of the transmit staging chunk and writing 0x184 sets bits 63:32. Writing 1 to bit 6 of 0x14 pushes the staged chunk and zeroes the stage, so a chunk written through 0x180 alone carries zeros in its upper word.
- R3: Transmit entries leave on `tx_out_byte` oldest first, least significant byte first, eight bytes per entry. A byte is held unchanged while `tx_out_valid` is 1 and `tx_out_ready` is 0.
- R4: Bit 6 of 0x14 reads 1 while the transmit FIFO (128 entries) has room. A push while it is full leaves the FIFO unchanged and sets sticky bit 8 of 0x14. Writing 1 to bit 8 clears it.
- R5: Accepted receive bytes fill an entry from its least significant byte up, and the eighth byte completes the entry. `rx_in_ready` is 0 while the receive FIFO (64 entries) is full.
- R6: 0x100 reads bits 31:0 and 0x104 reads bits 63:32 of the oldest receive entry. Bit 5 of 0x14 reads 1 while an entry is held. Writing 1 to bit 5 discards the oldest entry.
- R7: A release while the receive FIFO is empty changes no fill level or count and sets sticky bit 9 of 0x14. Writing 1 to bit 9 clears it.
- R8: Writing 1 to bit 0 of 0x20 empties the receive FIFO and drops a partly assembled entry. Writing 1 to bit 0 of 0x24 empties the transmit FIFO and restarts its byte position. Neither clear alters the running counts.
- R9: 0x30 (receive) and 0x34 (transmit) read the fill level in bits 15:0. Bits 31:16 read a running count: chunks released for receive, chunks accepted for transmit.
- R10: Writing 0 to bits 5 and 6 of 0x14, or writing a window word alone, moves no chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 10 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| tx_out_valid | output | 1 | Transmit byte available to the sequencer |
| tx_out_ready | input | 1 | Sequencer takes the transmit byte |
| tx_out_byte | output | 8 | Transmit byte |
| rx_in_valid | input | 1 | Sequencer offers a receive byte |
| rx_in_ready | output | 1 | Receive byte can be accepted |
| rx_in_byte | input | 8 | Receive byte |

## Verification
The transmit path is tested with a full two-word chunk, with a chunk written through the low word only, and with a run that fills all 128 entries. These cases separate byte ordering, the zero padding of the upper word and the refusal of an overfull push. The sequencer holds ready low for one cycle, which shows whether the byte is held. The receive path is tested with two complete entries, with a three-byte fragment that is cleared before fresh bytes arrive, and with a 512-byte run that fills the FIFO. These cases separate packing order, the dropping of a partly built entry and back-pressure. Releases on an empty FIFO and zero-valued flag writes confirm that only set flag bits move chunks.

// File: rtl/ipfifo_window.sv
module ipfifo_window #(
  parameter int TX_DEPTH = 128,
  parameter int RX_DEPTH = 64,
  parameter int AW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [7:0]    tx_out_byte,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [7:0]    rx_in_byte
);
  // depths must be powers of two; pointers wrap naturally
  localparam int TXP = $clog2(TX_DEPTH);
  localparam int RXP = $clog2(RX_DEPTH);
  localparam int TXC = $clog2(TX_DEPTH + 1);
  localparam int RXC = $clog2(RX_DEPTH + 1);
  localparam logic [TXC-1:0] TX_FULL = TXC'(TX_DEPTH);
  localparam logic [RXC-1:0] RX_FULL = RXC'(RX_DEPTH);

  localparam logic [AW-1:0] A_FLAG  = AW'('h014);
  localparam logic [AW-1:0] A_RXCTL = AW'('h020);
  localparam logic [AW-1:0] A_TXCTL = AW'('h024);
  localparam logic [AW-1:0] A_RXSTS = AW'('h030);
  localparam logic [AW-1:0] A_TXSTS = AW'('h034);
  localparam logic [AW-1:0] A_RXW0  = AW'('h100);
  localparam logic [AW-1:0] A_RXW1  = AW'('h104);
  localparam logic [AW-1:0] A_TXW0  = AW'('h180);
  localparam logic [AW-1:0] A_TXW1  = AW'('h184);

  logic [63:0]    txmem [TX_DEPTH];
  logic [63:0]    rxmem [RX_DEPTH];
  logic [63:0]    tx_stage, tx_head, rx_head;
  logic [55:0]    rx_asm;
  logic [TXP-1:0] tx_wp, tx_rp;
  logic [RXP-1:0] rx_wp, rx_rp;
  logic [TXC-1:0] tx_cnt;
  logic [RXC-1:0] rx_cnt;
  logic [2:0]     tx_bidx, rx_bidx;
  logic [15:0]    tx_moved, rx_moved;
  logic           tx_err, rx_err;

  wire wr_flag  = bus_wr && bus_addr == A_FLAG;
  wire tx_clr   = bus_wr && bus_addr == A_TXCTL && bus_wdata[0];
  wire rx_clr   = bus_wr && bus_addr == A_RXCTL && bus_wdata[0];
  wire tx_full  = tx_cnt == TX_FULL;
  wire rx_empty = rx_cnt == '0;
  wire push_req = wr_flag && bus_wdata[6] && !tx_clr;
  wire rel_req  = wr_flag && bus_wdata[5] && !rx_clr;
  wire tx_push  = push_req && !tx_full;
  wire rx_rel   = rel_req && !rx_empty;
  wire tx_take  = tx_out_valid && tx_out_ready && !tx_clr;
  wire tx_pop   = tx_take && tx_bidx == 3'd7;
  wire rx_take  = rx_in_valid && rx_in_ready && !rx_clr;
  wire rx_push  = rx_take && rx_bidx == 3'd7;

  assign tx_head      = txmem[tx_rp];
  assign rx_head      = rxmem[rx_rp];
  assign tx_out_valid = tx_cnt != '0;
  assign tx_out_byte  = tx_head[{tx_bidx, 3'b000} +: 8];
  assign rx_in_ready  = rx_cnt != RX_FULL;

  always_ff @(posedge clk) begin
    if (tx_push) txmem[tx_wp] <= tx_stage;
    if (rx_push) rxmem[rx_wp] <= {rx_in_byte, rx_asm};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_stage <= '0; tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      tx_bidx <= '0; tx_moved <= '0; tx_err <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_TXW0) tx_stage[31:0]  <= bus_wdata;
      if (bus_wr && bus_addr == A_TXW1) tx_stage[63:32] <= bus_wdata;
      if (tx_push) begin
        tx_stage <= '0;
        tx_wp    <= tx_wp + 1'b1;
        tx_moved <= tx_moved + 1'b1;
      end
      if (tx_clr) begin
        tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0; tx_bidx <= '0;
      end else begin
        tx_cnt <= tx_cnt + TXC'(tx_push) - TXC'(tx_pop);
        if (tx_take) tx_bidx <= tx_bidx + 1'b1;
        if (tx_pop)  tx_rp   <= tx_rp + 1'b1;
      end
      if (push_req && tx_full)               tx_err <= 1'b1;
      else if (wr_flag && bus_wdata[8])      tx_err <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_asm <= '0; rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      rx_bidx <= '0; rx_moved <= '0; rx_err <= 1'b0;
    end else begin
      if (rx_rel) rx_moved <= rx_moved + 1'b1;
      if (rx_clr) begin
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; rx_bidx <= '0; rx_asm <= '0;
      end else begin
        rx_cnt <= rx_cnt + RXC'(rx_push) - RXC'(rx_rel);
        if (rx_take) begin
          rx_bidx <= rx_bidx + 1'b1;
          if (rx_bidx != 3'd7) rx_asm[{rx_bidx, 3'b000} +: 8] <= rx_in_byte;
        end
        if (rx_push) rx_wp <= rx_wp + 1'b1;
        if (rx_rel)  rx_rp <= rx_rp + 1'b1;
      end
      if (rel_req && rx_empty)               rx_err <= 1'b1;
      else if (wr_flag && bus_wdata[9])      rx_err <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_FLAG:  bus_rdata = {22'b0, rx_err, tx_err, 1'b0, !tx_full, !rx_empty, 5'b0};
      A_RXSTS: bus_rdata = {rx_moved, 16'(rx_cnt)};
      A_TXSTS: bus_rdata = {tx_moved, 16'(tx_cnt)};
      A_RXW0:  bus_rdata = rx_head[31:0];
      A_RXW1:  bus_rdata = rx_head[63:32];
      default: bus_rdata = '0;
    endcase
  end

  a_r4_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TX_FULL);
  a_r5_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= RX_FULL);
  a_r4_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && tx_full) |=> (tx_err && tx_cnt != '0));
  a_r7_empty_release_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && rx_empty && !rx_take) |=> (rx_err && rx_cnt == '0));
  a_r3_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready && !tx_clr) |=> (tx_out_valid && $stable(tx_out_byte)));
  a_r8_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> !tx_out_valid);
  a_r8_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (rx_cnt == '0 && rx_in_ready));
endmodule

// File: tb/test_ipfifo_window.sv
module test_ipfifo_window;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_out_valid;
  logic        tx_out_ready = 1'b0;
  logic [7:0]  tx_out_byte;
  logic        rx_in_valid = 1'b0;
  logic        rx_in_ready;
  logic [7:0]  rx_in_byte = '0;

  int vectors = 0;
  int miscmp  = 0;
  bit done    = 0;

  ipfifo_window i_ipfifo_window (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_byte(tx_out_byte),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_byte(rx_in_byte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic feed(input logic [7:0] b);
    @(negedge clk);
    rx_in_valid = 1'b1; rx_in_byte = b;
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic take(output logic [7:0] b);
    @(negedge clk);
    b = tx_out_byte;
    tx_out_ready = 1'b1;
    @(negedge clk);
    tx_out_ready = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(10'h014, d); chk("R1 flags", d, 32'h40);
    rd(10'h030, d); chk("R1 rx status", d, 0);
    rd(10'h034, d); chk("R1 tx status", d, 0);
    chk("R1 tx_out_valid", 32'(tx_out_valid), 0);
    chk("R1 rx_in_ready", 32'(rx_in_ready), 1);
  endtask

  task automatic t_tx_basic;
    logic [31:0] d;
    logic [7:0]  b;
    logic [7:0]  exp [16];
    exp = '{8'h44, 8'h33, 8'h22, 8'h11, 8'h88, 8'h77, 8'h66, 8'h55,
            8'hDD, 8'hCC, 8'hBB, 8'hAA, 8'h00, 8'h00, 8'h00, 8'h00};
    wr(10'h180, 32'h11223344);
    wr(10'h184, 32'h55667788);
    rd(10'h034, d); chk("R10 window write alone", d, 0);
    wr(10'h014, 32'h0);
    rd(10'h034, d); chk("R10 zero flag write", d, 0);
    wr(10'h014, 32'h40);
    wr(10'h180, 32'hAABBCCDD);
    wr(10'h014, 32'h40);
    rd(10'h034, d); chk("R9 tx status after two pushes", d, {16'd2, 16'd2});
    @(negedge clk);
    b = tx_out_byte;
    @(negedge clk);
    chk("R3 byte held without ready", 32'(tx_out_byte), 32'(b));
    chk("R3 valid held", 32'(tx_out_valid), 1);
    for (int i = 0; i < 16; i++) begin
      take(b);
      chk(i < 8 ? "R3 tx byte order" : "R2 partial chunk padding", 32'(b), 32'(exp[i]));
    end
    chk("R3 drained", 32'(tx_out_valid), 0);
  endtask

  task automatic t_tx_full;
    logic [31:0] d;
    logic [7:0]  b;
    for (int k = 0; k < 128; k++) begin
      wr(10'h180, 32'(k + 8'h30));
      wr(10'h014, 32'h40);
    end
    rd(10'h014, d); chk("R4 no room flag", d, 32'h0);
    wr(10'h014, 32'h40);
    rd(10'h034, d); chk("R4 overfull push ignored", d, {16'd130, 16'd128});
    rd(10'h014, d); chk("R4 push error flag", d, 32'h100);
    wr(10'h014, 32'h100);
    rd(10'h014, d); chk("R4 error cleared", d, 32'h0);
    take(b);
    chk("R3 oldest entry first", 32'(b), 32'h30);
    wr(10'h024, 32'h1);
    chk("R8 tx clear empties", 32'(tx_out_valid), 0);
    rd(10'h034, d); chk("R8 tx clear keeps count", d, {16'd130, 16'd0});
    rd(10'h014, d); chk("R8 tx room after clear", d, 32'h40);
    wr(10'h180, 32'h000000EE);
    wr(10'h014, 32'h40);
    take(b);
    chk("R8 tx byte position restarted", 32'(b), 32'hEE);
    wr(10'h024, 32'h1);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    for (int i = 1; i <= 16; i++) feed(8'(i));
    rd(10'h014, d); chk("R6 data available flag", d, 32'h60);
    rd(10'h030, d); chk("R9 rx fill", d, {16'd0, 16'd2});
    rd(10'h100, d); chk("R5 rx low word", d, 32'h04030201);
    rd(10'h104, d); chk("R6 rx high word", d, 32'h08070605);
    wr(10'h014, 32'h20);
    rd(10'h100, d); chk("R6 release advances", d, 32'h0C0B0A09);
    rd(10'h030, d); chk("R9 rx status after release", d, {16'd1, 16'd1});
    wr(10'h014, 32'h20);
    rd(10'h014, d); chk("R6 no data flag", d, 32'h40);
  endtask

  task automatic t_rx_clear;
    logic [31:0] d;
    for (int i = 0; i < 3; i++) feed(8'hF0 + 8'(i));
    rd(10'h030, d); chk("R5 partial entry not counted", d, {16'd2, 16'd0});
    wr(10'h020, 32'h1);
    for (int i = 0; i < 8; i++) feed(8'h20 + 8'(i));
    rd(10'h100, d); chk("R8 rx clear drops fragment", d, 32'h23222120);
    rd(10'h104, d); chk("R8 rx clear high word", d, 32'h27262524);
    wr(10'h014, 32'h20);
    rd(10'h030, d); chk("R9 rx count", d, {16'd3, 16'd0});
  endtask

  task automatic t_rx_empty;
    logic [31:0] d;
    wr(10'h014, 32'h20);
    rd(10'h030, d); chk("R7 empty release ignored", d, {16'd3, 16'd0});
    rd(10'h014, d); chk("R7 release error flag", d, 32'h240);
    wr(10'h014, 32'h200);
    rd(10'h014, d); chk("R7 error cleared", d, 32'h40);
  endtask

  task automatic t_rx_full;
    logic [31:0] d;
    for (int i = 0; i < 512; i++) feed(8'(i));
    chk("R5 ready low when full", 32'(rx_in_ready), 0);
    feed(8'hFF);
    rd(10'h030, d); chk("R5 full fill", d, {16'd3, 16'd64});
    wr(10'h014, 32'h20);
    rd(10'h100, d); chk("R5 second entry after release", d, 32'h0B0A0908);
    chk("R5 ready after release", 32'(rx_in_ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_full();
    t_rx_basic();
    t_rx_clear();
    t_rx_empty();
    t_rx_full();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule